// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Atomic Set/Clear Output Control

This block is a general-purpose I/O controller for up to a few hundred pins, reached over a plain register bus with a byte address, a write strobe, write data and combinational read data. Pins are grouped 32 to a register set, and pin n lives in set n/32 at bit n mod 32. Each set has a direction register, an output latch, a write-one-to-set port, a write-one-to-clear port and a synchronized input-data register. The output latch can only be changed through the set and clear ports, so software can change single pins without a read-modify-write race.

The sets sit at fixed places in one address window. Set k starts at byte 0x10 + 0x28*k. Inside a set the registers are at these offsets: +0x00 direction, +0x04 output latch (read only), +0x08 set port, +0x0C clear port, +0x10 input data. Pad drivers are modelled by an output-enable vector and an output-value vector, one bit per pin. A pin-level vector comes back from the pads and passes through a two-flop synchronizer before software can read it. To make a pin an output without a glitch, software first loads its level through the set or clear port and then clears its direction bit.

Top module: `gpio_bank_top`

## Requirements
- R1: A synchronous active-low reset makes every implemented pin an input (direction bit 1, so the direction register reads all ones on implemented bits). It also clears the output latch, so pad_oe and pad_out are all zero.
- R2: A write to a set's set port (offset +0x08) forces to 1 each latch bit whose write-data bit is 1 and leaves every other latch bit unchanged. The change is visible on the next clock.
- R3: A write to a set's clear port (offset +0x0C) forces to 0 each latch bit whose write-data bit is 1 and leaves every other latch bit unchanged.
- R4: The direction register (offset +0x00) is a plain read/write register. Bit value 1 means input and 0 means output, and pad_oe[n] is the inverse of the pin's direction bit.
- R5: The input-data register (offset +0x10) returns the pad level through a two-flop synchronizer. A pin change is first readable after the second rising clock edge. The register reflects the pad even when the pin is an output, and it reads zero right after reset.
- R6: Reads of the output-latch, set-port and clear-port addresses all return the current output latch.
- R7: Set k decodes at base 0x10 + 0x28*k and controls pins 32k to 32k+31. A write to one set never changes another set.
- R8: Bits at or above NUM_PINS in the last set read as zero and cannot be written.
- R9: Addresses outside every set's 0x14-byte register span, and addresses that are not word aligned, read as zero and have no effect on writes.
- R10: pad_out always equals the output latch, including while the pin is an input, so an output level can be preloaded before the direction changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NUM_PINS | Pin levels returned from the pads |
| pad_oe | output | NUM_PINS | Per-pin output enable, 1 drives the pad |
| pad_out | output | NUM_PINS | Per-pin output value (the output latch) |

## Verification
The checker watches the following on every clock. Set-port and clear-port writes must change exactly the selected latch bits in the first set. The latch must hold whenever no latch port is written. Reset must clear the pad outputs. Input data must match the pad level from two edges earlier. The top bits of the last set, the low gap in the address map and misaligned addresses must read zero. Other behaviour can only be shown by the bench's scenarios: placing each set at its base address, isolating one set from another, direction read-back and its effect on pad_oe, preloading the latch while a pin is still an input, and the exact cycle at which a pad change becomes readable.

// File: rtl/gpio_bank_pkg.sv
// Shared constants, register kinds and address helpers for the GPIO bank.
// Assumes byte addressing and 32-bit words in every register set.
package gpio_bank_pkg;

    localparam int WORD_W     = 32;
    localparam int FIRST_BASE = 'h10;
    localparam int SET_STRIDE = 'h28;
    localparam int SET_SPAN   = 'h14;

    // Register kinds, numbered by their word offset inside a set
    typedef enum logic [2:0] {
        RK_DIR = 3'd0,
        RK_OUT = 3'd1,
        RK_SET = 3'd2,
        RK_CLR = 3'd3,
        RK_IN  = 3'd4
    } reg_kind_e;

    // Byte base address of register set k
    function automatic int set_base(input int k);
        return FIRST_BASE + SET_STRIDE * k;
    endfunction

    // Number of implemented pins in set k for a bank of num_pins pins
    function automatic int set_width(input int k, input int num_pins);
        int left;
        left = num_pins - WORD_W * k;
        return (left > WORD_W) ? WORD_W : left;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
// Address decoder for the GPIO bank.
// Turns a byte address into a one-hot set select and a register kind.
// Assumes word-aligned accesses; misaligned or unmapped addresses give no hit.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_SETS = 5
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_SETS-1:0] set_sel,
    output reg_kind_e           kind
);

    // Compare the address against each set window and pick the matching kind
    always_comb begin
        set_sel = '0;
        kind    = RK_DIR;
        for (int k = 0; k < NUM_SETS; k++) begin
            logic [ADDR_W-1:0] rel;
            rel = addr - ADDR_W'(set_base(k));
            if ((addr >= ADDR_W'(set_base(k))) &&
                (rel < ADDR_W'(SET_SPAN)) &&
                (rel[1:0] == 2'b00)) begin
                set_sel[k] = 1'b1;
                kind       = reg_kind_e'(rel[4:2]);
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-flop synchronizer for pad inputs.
// Assumes pad levels are asynchronous to clk; the output lags by STAGES edges.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift pad levels through the flop chain, clearing it on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_reg_set.sv
// One register set of the GPIO bank: direction, output latch and input data
// for up to 32 pins. The latch changes only through set and clear strobes.
// Assumes at most one strobe is active per cycle (one bus write per cycle).
module gpio_reg_set #(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] in_q
);

    // Direction register: plain read/write, reset to all inputs
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (wr_dir) dir_q <= wdata;
    end

    // Output latch: write-one-to-set and write-one-to-clear only
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (wr_set) latch_q <= latch_q | wdata;
        else if (wr_clr) latch_q <= latch_q & ~wdata;
    end

    gpio_in_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (in_q)
    );

endmodule

// File: rtl/gpio_bank_top.sv
// GPIO bank top: address decode, one register set per 32 pins, read mux and
// pad wiring. Assumes NUM_PINS fits in the address window given by ADDR_W.
module gpio_bank_top
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 144,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);

    localparam int NUM_SETS = (NUM_PINS + WORD_W - 1) / WORD_W;

    logic [NUM_SETS-1:0] set_sel;
    reg_kind_e           kind;
    logic [WORD_W-1:0]   rd_word [NUM_SETS];

    gpio_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_SETS (NUM_SETS)
    ) u_dec (
        .addr    (bus_addr),
        .set_sel (set_sel),
        .kind    (kind)
    );

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        localparam int W  = set_width(k, NUM_PINS);
        localparam int LO = WORD_W * k;

        logic [W-1:0] dir_q, latch_q, in_q;
        logic         wr_dir, wr_set, wr_clr;

        // Qualify the bus write with this set's select and the register kind
        always_comb begin
            wr_dir = bus_wr_en && set_sel[k] && (kind == RK_DIR);
            wr_set = bus_wr_en && set_sel[k] && (kind == RK_SET);
            wr_clr = bus_wr_en && set_sel[k] && (kind == RK_CLR);
        end

        gpio_reg_set #(
            .WIDTH       (W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_set (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_dir  (wr_dir),
            .wr_set  (wr_set),
            .wr_clr  (wr_clr),
            .wdata   (bus_wdata[W-1:0]),
            .pad_in  (pad_in[LO +: W]),
            .dir_q   (dir_q),
            .latch_q (latch_q),
            .in_q    (in_q)
        );

        // Drive the pads: enable where direction says output, value from latch
        assign pad_oe[LO +: W]  = ~dir_q;
        assign pad_out[LO +: W] = latch_q;

        // Form this set's read word, zero-extended above its pin count
        always_comb begin
            rd_word[k] = '0;
            unique case (kind)
                RK_DIR:                 rd_word[k][W-1:0] = dir_q;
                RK_OUT, RK_SET, RK_CLR: rd_word[k][W-1:0] = latch_q;
                RK_IN:                  rd_word[k][W-1:0] = in_q;
                default:                rd_word[k]        = '0;
            endcase
        end
    end

    // Read mux: OR the words of the selected set (select is one-hot or empty)
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_SETS; k++) begin
            if (set_sel[k]) bus_rdata = bus_rdata | rd_word[k];
        end
    end

endmodule

// File: rtl/gpio_bank_chk.sv
// Assertion checker for gpio_bank_top, attached by bind below.
// Observes only the top-level ports.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 144,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr_en,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic [WORD_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out
);

    localparam int NUM_SETS  = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int LAST_W    = set_width(NUM_SETS - 1, NUM_PINS);
    localparam int LAST_BASE = set_base(NUM_SETS - 1);

    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(FIRST_BASE + 'h08);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(FIRST_BASE + 'h0C);
    localparam logic [ADDR_W-1:0] A_IN0  = ADDR_W'(FIRST_BASE + 'h10);

    // Does this address hit any set or clear port of any set
    function automatic logic latch_port(input logic [ADDR_W-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NUM_SETS; k++) begin
            if (a == ADDR_W'(set_base(k) + 'h08) || a == ADDR_W'(set_base(k) + 'h0C))
                hit = 1'b1;
        end
        return hit;
    endfunction

    // Count edges since reset release, saturating, for the synchronizer window
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_PADS: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0)); // R1

    AST_SET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == A_SET0) |=>
        pad_out[WORD_W-1:0] == $past(pad_out[WORD_W-1:0] | bus_wdata)); // R2

    AST_CLR_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == A_CLR0) |=>
        pad_out[WORD_W-1:0] == $past(pad_out[WORD_W-1:0] & ~bus_wdata)); // R3

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && latch_port(bus_addr)) |=> $stable(pad_out)); // R10

    AST_IN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bus_addr == A_IN0) |->
        bus_rdata == $past(pad_in[WORD_W-1:0], 2)); // R5

    AST_LOW_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < ADDR_W'(FIRST_BASE)) |-> bus_rdata == '0); // R9

    AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> bus_rdata == '0); // R9

    if (LAST_W < WORD_W) begin : g_top_bits
        AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr >= ADDR_W'(LAST_BASE) && bus_addr < ADDR_W'(LAST_BASE + SET_SPAN)) |->
            bus_rdata[WORD_W-1:LAST_W] == '0); // R8
    end

endmodule

bind gpio_bank_top gpio_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/sim_gpio_bank_top.sv
// Bench for gpio_bank_top: a vector table walked by one loop, then directed
// tests for pads, synchronizer timing, set isolation and reset.
module sim_gpio_bank_top;

    localparam int NUM_PINS = 144;
    localparam int ADDR_W   = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic                bus_wr_en = 1'b0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NUM_PINS-1:0] pad_in = '0;
    logic [NUM_PINS-1:0] pad_oe;
    logic [NUM_PINS-1:0] pad_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    gpio_bank_top #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } step_t;

    localparam int N_STEPS = 28;
    localparam step_t STEPS [N_STEPS] = '{
        '{1'b0, 8'h10, 32'hFFFF_FFFF, 4'd1},  // R1 direction resets to inputs
        '{1'b0, 8'h14, 32'h0000_0000, 4'd1},  // R1 latch cleared
        '{1'b1, 8'h18, 32'hA5A5_0F0F, 4'd2},  // R2
        '{1'b0, 8'h14, 32'hA5A5_0F0F, 4'd2},
        '{1'b1, 8'h18, 32'h0000_F000, 4'd2},
        '{1'b0, 8'h14, 32'hA5A5_FF0F, 4'd2},  // R2 zero bits untouched
        '{1'b1, 8'h1C, 32'h0000_000F, 4'd3},  // R3
        '{1'b0, 8'h14, 32'hA5A5_FF00, 4'd3},
        '{1'b0, 8'h18, 32'hA5A5_FF00, 4'd6},  // R6 set port reads latch
        '{1'b0, 8'h1C, 32'hA5A5_FF00, 4'd6},  // R6 clear port reads latch
        '{1'b1, 8'h10, 32'hFFFF_0000, 4'd4},  // R4
        '{1'b0, 8'h10, 32'hFFFF_0000, 4'd4},
        '{1'b1, 8'h40, 32'h1234_5678, 4'd7},  // R7 set 1 at 0x38
        '{1'b0, 8'h3C, 32'h1234_5678, 4'd7},
        '{1'b0, 8'h14, 32'hA5A5_FF00, 4'd7},  // R7 set 0 untouched
        '{1'b1, 8'hB0, 32'h0000_0000, 4'd4},
        '{1'b0, 8'hB0, 32'h0000_0000, 4'd4},
        '{1'b1, 8'hB0, 32'hFFFF_FFFF, 4'd8},  // R8
        '{1'b0, 8'hB0, 32'h0000_FFFF, 4'd8},
        '{1'b1, 8'hB8, 32'hFFFF_FFFF, 4'd8},
        '{1'b0, 8'hB4, 32'h0000_FFFF, 4'd8},
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 4'd9},  // R9 below first set
        '{1'b0, 8'h00, 32'h0000_0000, 4'd9},
        '{1'b1, 8'h24, 32'hFFFF_FFFF, 4'd9},  // R9 gap after set 0
        '{1'b0, 8'h24, 32'h0000_0000, 4'd9},
        '{1'b1, 8'h19, 32'hFFFF_FFFF, 4'd9},  // R9 misaligned set port
        '{1'b0, 8'h14, 32'hA5A5_FF00, 4'd9},
        '{1'b0, 8'h20, 32'h0000_0000, 4'd5}   // R5 pads low since reset
    };

    // Compare one value and report a failure with the requirement tag
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus write cycle, driven from the falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    // Read a register (combinational) and compare it
    task automatic bus_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        #20000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pad_oe", pad_oe[31:0], 32'h0);
        check("R1 pad_out", pad_out[31:0], 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < N_STEPS; i++) begin
            if (STEPS[i].wr) bus_write(STEPS[i].addr, STEPS[i].data);
            else bus_check(STEPS[i].addr, STEPS[i].data, $sformatf("R%0d step %0d", STEPS[i].req, i));
        end

        // R4, R10: pads follow direction and latch
        @(negedge clk);
        check("R10 pad_out set0", pad_out[31:0], 32'hA5A5_FF00);
        check("R4 pad_oe set0", pad_oe[31:0], 32'h0000_FFFF);
        check("R7 pad_out set1", pad_out[63:32], 32'h1234_5678);
        check("R10 latch on input pins", {16'h0, pad_out[143:128]}, 32'h0000_FFFF);
        check("R4 pad_oe inputs", {16'h0, pad_oe[143:128]}, 32'h0);

        // R5: two-edge synchronizer lag, reads pad even on output pins
        @(negedge clk);
        pad_in[31:0] = 32'h5A5A_1234;
        bus_addr = 8'h20;
        @(posedge clk); #1;
        check("R5 after one edge", bus_rdata, 32'h0);
        @(posedge clk); #1;
        check("R5 after two edges", bus_rdata, 32'h5A5A_1234);

        // R7: pin 70 sits in set 2 at bit 6, input data at 0x70
        @(negedge clk);
        pad_in[70] = 1'b1;
        repeat (3) @(negedge clk);
        bus_check(8'h70, 32'h0000_0040, "R7 pin 70");

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_check(8'h10, 32'hFFFF_FFFF, "R1 dir after reset");
        check("R1 pad_out after reset", pad_out[31:0], 32'h0);
        check("R1 pad_oe after reset", pad_oe[31:0], 32'h0);
        bus_check(8'h14, 32'h0, "R1 latch after reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule